// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing side of a successive-approximation converter. A 7-bit prescaler divides the system clock down to a conversion clock, with the division picked by a 3-bit select. A state machine then steps each conversion through its conversion-clock half periods. It pulses a sample-and-hold strobe at the point where the analog front end must capture, and pulses a completion event at the end. At completion it loads a 10-bit result from a digital input port and raises a sticky interrupt flag.

A conversion can begin in three ways. Software can request one with a start pulse. An external trigger can launch one when auto-triggering is enabled. In free-running mode, each completion starts the next conversion at once. The first conversion after the block is switched on runs longer, so that the analog circuitry can settle. In differential mode with external auto-triggering, every conversion is this long form.

States: `ST_OFF` (disabled, prescaler cleared), `ST_IDLE` (enabled, no request), `ST_WAIT` (start requested, waiting for a conversion-clock rising tick), `ST_ALIGN` (trigger taken and prescaler restarted, waiting for the first falling tick), `ST_CONV` (counting half periods). The transitions are:
- OFF→IDLE when enable rises.
- any→OFF when enable falls.
- IDLE→ALIGN on an accepted trigger edge.
- IDLE→WAIT on a start request.
- WAIT→CONV on a rising tick.
- ALIGN→CONV on a falling tick.
- CONV→CONV, restarted, at completion in free-running mode.
- CONV→IDLE at completion otherwise.

Top module: `adc_conv_seq`

## Requirements
- R1: The division ratio N is 2 for select codes 0 and 1, and 4, 8, 16, 32, 64 and 128 for codes 2 to 7. In free-running mode, consecutive completion pulses are exactly 13·N system cycles apart.
- R2: While `en` is low, `busy` is low, the prescaler is held cleared, and start pulses and triggers produce no conversion.
- R3: A start pulse sets `busy`. A normal single conversion completes between 13·N+1 and 14·N cycles after the start pulse. In single mode, `busy` falls in the same cycle that `done` pulses.
- R4: The first conversion after `en` rises completes between 25·N+1 and 26·N cycles after its start pulse.
- R5: The sample-and-hold strobe comes 1.5 conversion-clock periods after the start of a normal conversion and 13.5 after the start of a long one. In both cases it therefore precedes `done` by exactly 11.5·N cycles.
- R6: At completion, `result` takes the value of `din` and `irq_flag` is set.
- R7: `irq_flag` stays set until `flag_clr` is pulsed. If a completion and a clear coincide, the flag stays set.
- R8: With `auto_en` set, a rising edge on `trig_in` restarts the prescaler. Counting the first clock edge that samples the trigger high as cycle 0, the strobe appears 2·N+2 cycles later and a normal conversion's `done` appears 13·N+N/2+2 cycles later.
- R9: In free-running mode, `busy` stays high through each completion, and a new conversion begins without any further start request.
- R10: With `diff_mode` and `auto_en` both set and `free_run` clear, every conversion is the long form: `done` appears 25·N+N/2+2 cycles after the trigger.
- R11: A trigger edge that arrives while a conversion is in progress is ignored. Completion timing is unchanged and only one `done` pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Converter enable |
| start_set | input | 1 | One-cycle start request |
| psel | input | 3 | Prescaler select code |
| auto_en | input | 1 | Auto-trigger enable |
| trig_in | input | 1 | Asynchronous trigger source |
| free_run | input | 1 | Free-running mode |
| diff_mode | input | 1 | Differential mode |
| flag_clr | input | 1 | Write-one clear of the interrupt flag |
| din | input | 10 | Digital conversion value from the analog side |
| busy | output | 1 | Start bit read-back: high while a conversion is pending or running |
| sh_strobe | output | 1 | One-cycle sample-and-hold pulse |
| done | output | 1 | One-cycle completion pulse |
| result | output | 10 | Latched conversion result |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
The free-running conversion interval is measured at all eight select codes. Equal spacing at codes 0 and 1, and doubling from code to code, separate a wrong tap from a wrong conversion length. Software starts are tried with a first (long) conversion and then a normal one. This tells the 25-cycle and 13-cycle lengths apart, and the fixed strobe-to-done gap shows that the strobe point moves with the length. Triggered starts are timed exactly from the trigger edge, in single-ended and differential mode. A second trigger is sent in the middle of a conversion to show that it is ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_WAIT,
        ST_ALIGN,
        ST_CONV
    } seq_state_t;

    // log2 of the division ratio minus one for a select code
    function automatic logic [2:0] tap_index(input logic [2:0] sel);
        return (sel < 3'd2) ? 3'd0 : 3'(sel - 3'd1);
    endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int CNT_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       rise_tk,
    output logic       fall_tk
);
    import adc_seq_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] low;

    always_comb begin
        mask    = CNT_W'((1 << (tap_index(sel) + 1)) - 1);
        half_m1 = CNT_W'((1 << tap_index(sel)) - 1);
        low     = cnt & mask;
        rise_tk = run && !restart && (low == mask);
        fall_tk = run && !restart && (low == half_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || restart)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_evt
);
    logic [STAGES:0] shr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shr <= '0;
        else
            shr <= {shr[STAGES-1:0], async_in};
    end

    assign rise_evt = shr[STAGES-1] && !shr[STAGES];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int RES_W      = 10,
    parameter int PRE_W      = 7,
    parameter int NORM_CYC   = 13,
    parameter int FIRST_CYC  = 25,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start_set,
    input  logic [2:0]       psel,
    input  logic             auto_en,
    input  logic             trig_in,
    input  logic             free_run,
    input  logic             diff_mode,
    input  logic             flag_clr,
    input  logic [RES_W-1:0] din,
    output logic             busy,
    output logic             sh_strobe,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             irq_flag
);
    import adc_seq_pkg::*;

    localparam int HW          = $clog2(2 * FIRST_CYC + 1);
    localparam logic [HW-1:0] NORM_END  = HW'(2 * NORM_CYC);
    localparam logic [HW-1:0] FIRST_END = HW'(2 * FIRST_CYC);
    localparam logic [HW-1:0] NORM_SH   = HW'(3);
    localparam logic [HW-1:0] FIRST_SH  = HW'(2 * (FIRST_CYC - NORM_CYC) + 3);

    seq_state_t state, nxt;
    logic [HW-1:0] half, half_nxt;
    logic          first_pend, start_bit;
    logic          rise_tk, fall_tk, tick, trig_evt, trig_go;
    logic          long_conv, hit_sh, hit_end;
    logic [HW-1:0] end_half, sh_half;

    adc_prescaler #(.CNT_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(en), .restart(trig_go),
        .sel(psel), .rise_tk(rise_tk), .fall_tk(fall_tk)
    );

    adc_trig_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise_evt(trig_evt)
    );

    always_comb begin
        tick      = rise_tk || fall_tk;
        trig_go   = en && auto_en && trig_evt && (state == ST_IDLE);
        long_conv = first_pend || (diff_mode && auto_en && !free_run);
        end_half  = long_conv ? FIRST_END : NORM_END;
        sh_half   = long_conv ? FIRST_SH : NORM_SH;
        hit_sh    = (state == ST_CONV) && tick && (half + 1'b1 == sh_half);
        hit_end   = (state == ST_CONV) && tick && (half + 1'b1 == end_half);
    end

    // next-state logic
    always_comb begin
        nxt      = state;
        half_nxt = half;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   nxt = ST_IDLE;
                ST_IDLE: begin
                    if (trig_go)
                        nxt = ST_ALIGN;
                    else if (start_bit || start_set)
                        nxt = ST_WAIT;
                end
                ST_WAIT: if (rise_tk) begin
                    nxt      = ST_CONV;
                    half_nxt = '0;
                end
                ST_ALIGN: if (fall_tk) begin
                    nxt      = ST_CONV;
                    half_nxt = '0;
                end
                ST_CONV: begin
                    if (hit_end) begin
                        nxt      = free_run ? ST_CONV : ST_IDLE;
                        half_nxt = '0;
                    end else if (tick) begin
                        half_nxt = half + 1'b1;
                    end
                end
                default:  nxt = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            half  <= '0;
        end else begin
            state <= nxt;
            half  <= half_nxt;
        end
    end

    // outputs and architectural bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit  <= 1'b0;
            first_pend <= 1'b1;
            irq_flag   <= 1'b0;
            result     <= '0;
            sh_strobe  <= 1'b0;
            done       <= 1'b0;
        end else begin
            sh_strobe <= hit_sh;
            done      <= hit_end;
            if (!en) begin
                start_bit  <= 1'b0;
                first_pend <= 1'b1;
            end else begin
                if (start_set || trig_go)
                    start_bit <= 1'b1;
                else if (hit_end && !free_run)
                    start_bit <= 1'b0;
                if (hit_end)
                    first_pend <= 1'b0;
            end
            if (hit_end) begin
                result   <= din;
                irq_flag <= 1'b1;
            end else if (flag_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    assign busy = start_bit;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic free_run,
    input logic busy,
    input logic sh_strobe,
    input logic done,
    input logic irq_flag,
    input logic flag_clr
);
    assert_off_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    assert_done_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_strobe_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sh_strobe);
    assert_strobe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sh_strobe |-> busy);
    assert_flag_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq_flag);
    assert_flag_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> done);
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clr) |=> irq_flag);
    assert_free_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(free_run) && $past(en)) |-> busy);
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .free_run(free_run), .busy(busy),
    .sh_strobe(sh_strobe), .done(done), .irq_flag(irq_flag), .flag_clr(flag_clr)
);

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 0, start_set = 0, auto_en = 0, trig_in = 0;
    logic       free_run = 0, diff_mode = 0, flag_clr = 0;
    logic [2:0] psel = 0;
    logic [9:0] din = 0;
    logic       busy, sh_strobe, done, irq_flag;
    logic [9:0] result;

    int cyc = 0, done_cnt = 0, sh_cnt = 0, last_done = 0, last_sh = 0;
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // select code -> free-running done spacing (13*N)
    localparam int VEC_N = 8;
    localparam int VEC_SEL [VEC_N] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam int VEC_GAP [VEC_N] = '{26, 26, 52, 104, 208, 416, 832, 1664};

    adc_conv_seq dut (
        .clk(clk), .rst_n(rst_n), .en(en), .start_set(start_set), .psel(psel),
        .auto_en(auto_en), .trig_in(trig_in), .free_run(free_run),
        .diff_mode(diff_mode), .flag_clr(flag_clr), .din(din), .busy(busy),
        .sh_strobe(sh_strobe), .done(done), .result(result), .irq_flag(irq_flag)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (rst_n) begin
        if (done)      begin done_cnt <= done_cnt + 1; last_done <= cyc; end
        if (sh_strobe) begin sh_cnt <= sh_cnt + 1;     last_sh <= cyc;   end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin @(negedge clk); #1; end
    endtask

    task automatic wait_done(input int lim);
        int c0;
        c0 = done_cnt;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk); #1;
            if (done_cnt != c0) break;
        end
    endtask

    task automatic pulse_start(output int at);
        @(negedge clk); start_set = 1; at = cyc + 1;
        @(negedge clk); start_set = 0; #1;
    endtask

    task automatic pulse_trig(output int at);
        @(negedge clk); trig_in = 1; at = cyc + 1;
        step(3);
        @(negedge clk); trig_in = 0; #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int t0, c0, gap, nn;
        step(3);
        rst_n = 1;
        step(1);
        chk(!busy && !done && !irq_flag && result == 0, "reset", busy, 0);

        // R2: disabled block ignores start and trigger
        auto_en = 1;
        pulse_start(t0);
        pulse_trig(t0);
        step(300);
        chk(!busy, "R2 busy", busy, 0);
        chk(done_cnt == 0, "R2 done", done_cnt, 0);
        auto_en = 0;

        // R1 / R9 / R5: free-running spacing over all select codes
        for (int v = 0; v < VEC_N; v++) begin
            en = 0; psel = 3'(VEC_SEL[v]); step(2);
            en = 1; free_run = 1;
            pulse_start(t0);
            wait_done(40000);
            wait_done(40000);
            c0 = last_done;
            wait_done(40000);
            gap = last_done - c0;
            chk(gap == VEC_GAP[v], "R1 free-run gap", gap, VEC_GAP[v]);
            chk(busy, "R9 busy stays high", busy, 1);
            nn = VEC_GAP[v] / 13;
            chk(last_done - last_sh == (23 * nn) / 2, "R5 normal strobe", last_done - last_sh, (23 * nn) / 2);
            free_run = 0;
            en = 0;
        end
        step(2);

        // R4 / R6 / R3: first conversion after enable, N=4
        psel = 3'd2; en = 1; din = 10'h2A5;
        flag_clr = 1; step(1); flag_clr = 0;
        pulse_start(t0);
        chk(busy, "R3 busy after start", busy, 1);
        wait_done(500);
        chk(last_done - t0 >= 101 && last_done - t0 <= 104, "R4 first length", last_done - t0, 101);
        chk(!busy, "R3 busy cleared with done", busy, 0);
        chk(last_done - last_sh == 46, "R5 first strobe", last_done - last_sh, 46);
        chk(result == 10'h2A5, "R6 result", result, 10'h2A5);
        chk(irq_flag, "R6 flag set", irq_flag, 1);
        step(50);
        chk(irq_flag, "R7 flag sticky", irq_flag, 1);
        @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0; #1;
        chk(!irq_flag, "R7 flag cleared", irq_flag, 0);

        // R3: normal single conversion
        din = 10'h11B;
        pulse_start(t0);
        wait_done(500);
        chk(last_done - t0 >= 53 && last_done - t0 <= 56, "R3 normal length", last_done - t0, 53);
        chk(result == 10'h11B, "R6 second result", result, 10'h11B);

        // R8: triggered conversion, N=8
        psel = 3'd3; auto_en = 1; step(5);
        c0 = sh_cnt;
        pulse_trig(t0);
        wait_done(1000);
        chk(last_sh - t0 == 18, "R8 strobe delay", last_sh - t0, 18);
        chk(last_done - t0 == 110, "R8 done delay", last_done - t0, 110);

        // R11: trigger during conversion ignored
        step(10);
        c0 = done_cnt;
        pulse_trig(t0);
        step(30);
        pulse_trig(gap);
        wait_done(1000);
        chk(last_done - t0 == 110, "R11 timing kept", last_done - t0, 110);
        step(200);
        chk(done_cnt == c0 + 1, "R11 single done", done_cnt - c0, 1);
        chk(!busy, "R11 idle after", busy, 0);

        // R10: differential with external trigger is always long
        diff_mode = 1; step(5);
        pulse_trig(t0);
        wait_done(2000);
        chk(last_done - t0 == 206, "R10 long triggered", last_done - t0, 206);
        step(10);
        pulse_trig(t0);
        wait_done(2000);
        chk(last_done - t0 == 206, "R10 long again", last_done - t0, 206);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule